// File: doc/BRIEF.md
# Multi-Channel Event Scaler Bank

This block counts events on a wide set of asynchronous digital inputs. Each input is brought into the system clock domain by a two-flop synchroniser. Its own counter then advances by one on every rising edge of the synchronised level. Inputs in one configurable index range, the general-purpose pins, first pass through a stability filter. In that range a level change counts only once the input has held its new value for a set number of cycles. One more counter sits after the last input counter and advances on every system clock cycle. This gives software a time base for turning counts into rates.

A small host register interface controls the bank. A write to the control register can snapshot every live counter into its latch register in one cycle, clear every live counter, or do both at once. When both are requested together, the snapshot holds the values from before the clear. A write to the scaler register selects one latched counter by the upper half of the write data. A read of the scaler register then returns the selected latched value. A read of the control register returns the number of inputs. Software adds one to that number to cover the clock counter.

Top module: `event_scaler_bank`

## Requirements
- R1: Each input channel counter increments by exactly one per rising edge of its synchronised input. A level held high, or a falling edge, adds nothing.
- R2: The counter at index NUM_IN advances by one on every clock cycle. It restarts from zero when a clear is requested.
- R3: A read with host_addr = 0 returns NUM_IN, zero-extended to 32 bits.
- R4: A write with host_addr = 0 and data bit 0 set copies every live counter into its latch in that cycle. Latches are unchanged at all other times.
- R5: A write with host_addr = 0 and data bit 1 set clears every live counter. The latched values are not changed.
- R6: When bits 0 and 1 are both set in one control write, the latches receive the values from before the clear, and the counters restart from zero.
- R7: A write with host_addr = 1 selects scaler index host_wdata[31:16]. A read with host_addr = 1 returns that scaler's latched value, zero-extended. An index above NUM_IN reads as 0.
- R8: On channels DEB_LO..DEB_HI, a pulse shorter than DEB_CYCLES cycles is not counted. A pulse held for longer than DEB_CYCLES cycles in both its high and low phases counts once.
- R9: Channels outside DEB_LO..DEB_HI count pulses as short as three cycles without filtering.
- R10: Counters are CNT_W bits wide and wrap from all-ones to zero without any indication.
- R11: After reset all live counters, all latches and the scaler select are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_bus | input | NUM_IN | Asynchronous event inputs, one bit per channel |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 1 | Register select: 0 control/input count, 1 scaler select/data |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr, combinational |

## Verification
The bench uses a reduced bank of eight inputs with two filtered channels, 8-bit counters and an 8-cycle filter. It first gives every channel a different number of clean pulses, so a crossed channel or a wrong readback index shows up as a wrong count. Trains of short glitches are then applied to the filtered and the unfiltered channels. The glitches must count on the unfiltered channels and vanish on the filtered ones, and one long held level must count only once. Separate latch, clear and combined latch-clear writes follow extra pulses. This tells a latch taken before the clear apart from one taken after it. Runs of idle cycles of known length, both below and beyond the counter range, check the clock counter and the wrap.

// File: rtl/scaler_pkg.sv
// Shared constants for the event scaler bank: register addresses and
// control bit positions. Assumes a one-bit register address space.
package scaler_pkg;
    localparam logic REG_CTRL   = 1'b0;  // write: control, read: input count
    localparam logic REG_SCALER = 1'b1;  // write: select, read: latched data
    localparam int   CTL_LATCH  = 0;     // control bit: snapshot counters
    localparam int   CTL_ZERO   = 1;     // control bit: clear counters
endpackage

// File: rtl/in_sync.sv
// Two-flop synchroniser for one asynchronous input.
// Assumes the input has no timing relationship to clk.
module in_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta;

    // Shift the input through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta     <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            meta     <= async_in;
            sync_out <= meta;
        end
    end
endmodule

// File: rtl/level_filter.sv
// Stability filter: the output follows the input only after the input has
// differed from the output for STABLE_CYCLES consecutive cycles.
// Assumes the input is already synchronous to clk.
module level_filter #(
    parameter int STABLE_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_out
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [CW-1:0] run;

    // Count cycles of disagreement, and accept the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= '0;
            level_out <= 1'b0;
        end else if (level_in == level_out) begin
            run <= '0;
        end else if (run == LAST) begin
            run       <= '0;
            level_out <= level_in;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/scaler_cell.sv
// One scaler: a live counter that advances on an increment pulse and
// a latch register loaded from it on command. A clear beats an increment
// in the same cycle. The latch always samples the pre-update value.
module scaler_cell #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             latch_cmd,
    input  logic             zero_cmd,
    output logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] held
);
    // Live counter: clear, count or hold; wraps at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)         live <= '0;
        else if (zero_cmd)  live <= '0;
        else if (inc)       live <= live + 1'b1;
    end

    // Snapshot register: loads the current live value on command.
    always_ff @(posedge clk) begin
        if (!rst_n)         held <= '0;
        else if (latch_cmd) held <= live;
    end
endmodule

// File: rtl/event_scaler_bank.sv
// Bank of NUM_IN edge-counting scalers plus one clock-cycle scaler, with a
// host register port for snapshot, clear, select and readback.
// Assumes in_bus is asynchronous and the host port is synchronous to clk.
module event_scaler_bank #(
    parameter int NUM_IN     = 59,
    parameter int DEB_LO     = 40,
    parameter int DEB_HI     = 57,
    parameter int DEB_CYCLES = 1024,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] in_bus,
    input  logic              host_wr,
    input  logic              host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata
);
    import scaler_pkg::*;

    localparam int NUM_CH = NUM_IN + 1;

    logic [NUM_IN-1:0]            lvl;
    logic [NUM_IN-1:0]            lvl_d;
    logic [NUM_CH-1:0]            inc;
    logic [NUM_CH-1:0][CNT_W-1:0] live_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0] held_cnt;
    logic [15:0]                  sel;
    logic                         latch_cmd;
    logic                         zero_cmd;

    assign latch_cmd = host_wr && (host_addr == REG_CTRL) && host_wdata[CTL_LATCH];
    assign zero_cmd  = host_wr && (host_addr == REG_CTRL) && host_wdata[CTL_ZERO];

    // Per-input conditioning: synchronise, and filter only the chosen range.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        logic s;
        in_sync u_sync (.clk(clk), .rst_n(rst_n), .async_in(in_bus[i]), .sync_out(s));
        if (i >= DEB_LO && i <= DEB_HI) begin : g_filt
            level_filter #(.STABLE_CYCLES(DEB_CYCLES)) u_filt (
                .clk(clk), .rst_n(rst_n), .level_in(s), .level_out(lvl[i]));
        end else begin : g_pass
            assign lvl[i] = s;
        end
    end

    // Previous conditioned level, for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= lvl;
    end

    assign inc = {1'b1, lvl & ~lvl_d};

    // Scaler cells: NUM_IN input scalers, then the clock-cycle scaler.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cell
        scaler_cell #(.CNT_W(CNT_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .inc(inc[c]),
            .latch_cmd(latch_cmd), .zero_cmd(zero_cmd),
            .live(live_cnt[c]), .held(held_cnt[c]));
    end

    // Scaler select register, loaded from the upper half of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  sel <= '0;
        else if (host_wr && host_addr == REG_SCALER) sel <= host_wdata[31:16];
    end

    // Read mux: input count, or the selected latch (0 when out of range).
    always_comb begin
        host_rdata = '0;
        if (host_addr == REG_CTRL) begin
            host_rdata = 32'(NUM_IN);
        end else begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (32'(sel) == k) host_rdata = 32'(held_cnt[k]);
            end
        end
    end
endmodule

// File: rtl/scaler_bank_chk.sv
// Checker for event_scaler_bank: decodes the host commands from the ports
// and relates them to the live and latched counters over time.
module scaler_bank_chk #(
    parameter int NUM_CH = 60,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         host_wr,
    input logic                         host_addr,
    input logic [31:0]                  host_wdata,
    input logic [NUM_CH-1:0][CNT_W-1:0] live_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] held_cnt
);
    logic lc, zc;
    assign lc = host_wr && !host_addr && host_wdata[0];
    assign zc = host_wr && !host_addr && host_wdata[1];

    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        lc |=> held_cnt == $past(live_cnt)); // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lc |=> $stable(held_cnt)); // R4
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        zc |=> live_cnt == '0); // R5
    AST_CLOCK_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !zc |=> live_cnt[NUM_CH-1] == $past(live_cnt[NUM_CH-1]) + 1'b1); // R2

    for (genvar c = 0; c < NUM_CH - 1; c++) begin : g_step
        AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !zc |=> (live_cnt[c] == $past(live_cnt[c])) ||
                    (live_cnt[c] == $past(live_cnt[c]) + 1'b1)); // R1
    end
endmodule

bind event_scaler_bank scaler_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .live_cnt(live_cnt), .held_cnt(held_cnt));

// File: tb/sim_event_scaler_bank.sv
// Bench for event_scaler_bank in a reduced configuration.
module sim_event_scaler_bank;
    localparam int NI  = 8;
    localparam int DLO = 5;
    localparam int DHI = 6;
    localparam int DC  = 8;
    localparam int CW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] in_bus = '0;
    logic          host_wr = 1'b0;
    logic          host_addr = 1'b0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    event_scaler_bank #(.NUM_IN(NI), .DEB_LO(DLO), .DEB_HI(DHI),
                        .DEB_CYCLES(DC), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_bus(in_bus), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; the write happens at the following posedge.
    task automatic wr(input logic a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic rd_sel(input int idx, output logic [31:0] v);
        wr(1'b1, 32'(idx) << 16);
        host_addr = 1'b1;
        #1 v = host_rdata;
    endtask

    task automatic pulse(input int ch, input int hi, input int lo);
        in_bus[ch] = 1'b1;
        repeat (hi) @(negedge clk);
        in_bus[ch] = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    function automatic bit filt(input int ch);
        return ch >= DLO && ch <= DHI;
    endfunction

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state of latches and select
        for (int c = 0; c <= NI; c++) begin
            rd_sel(c, v);
            chk("R11 latch after reset", v, 0);
        end
        host_addr = 1'b0; #1;
        chk("R3 input count", host_rdata, NI);

        // R1/R8/R9: channel c receives c+1 clean pulses
        wr(1'b0, 32'h2);
        for (int c = 0; c < NI; c++)
            for (int p = 0; p <= c; p++)
                if (filt(c)) pulse(c, 2*DC, 2*DC); else pulse(c, 3, 3);
        repeat (6) @(negedge clk);
        wr(1'b0, 32'h1);
        for (int c = 0; c < NI; c++) begin
            rd_sel(c, v);
            chk(filt(c) ? "R8 long pulses" : "R1 R9 clean pulses", v, c + 1);
        end

        // R6: one more pulse each, then a combined latch+clear
        for (int c = 0; c < NI; c++)
            if (filt(c)) pulse(c, 2*DC, 2*DC); else pulse(c, 3, 3);
        repeat (6) @(negedge clk);
        wr(1'b0, 32'h3);
        for (int c = 0; c < NI; c++) begin
            rd_sel(c, v);
            chk("R6 pre-clear snapshot", v, c + 2);
        end
        // R5: a clear alone leaves latches untouched
        wr(1'b0, 32'h2);
        rd_sel(3, v);
        chk("R5 latch kept after clear", v, 5);

        // R2: clear, 10 idle cycles, latch
        wr(1'b0, 32'h2);
        repeat (10) @(negedge clk);
        wr(1'b0, 32'h1);
        rd_sel(NI, v);
        chk("R2 clock scaler", v, 10);
        for (int c = 0; c < NI; c++) begin
            rd_sel(c, v);
            chk("R5 counters cleared", v, 0);
        end

        // R8/R9/R1: glitches on every channel, a long level on channel 0
        wr(1'b0, 32'h2);
        for (int g = 0; g < 4; g++)
            for (int c = 1; c < NI; c++) pulse(c, 3, 3);
        in_bus[0] = 1'b1;
        repeat (30) @(negedge clk);
        repeat (6) @(negedge clk);
        wr(1'b0, 32'h1);
        rd_sel(0, v);
        chk("R1 held level counts once", v, 1);
        for (int c = 1; c < NI; c++) begin
            rd_sel(c, v);
            chk(filt(c) ? "R8 glitches ignored" : "R9 glitches counted", v, filt(c) ? 0 : 4);
        end
        in_bus[0] = 1'b0;

        // R10: clock scaler wrap after 300 idle cycles
        wr(1'b0, 32'h2);
        repeat (300) @(negedge clk);
        wr(1'b0, 32'h1);
        rd_sel(NI, v);
        chk("R10 wrap", v, 300 % (1 << CW));

        // R7: out-of-range selects read as zero
        rd_sel(NI + 1, v);
        chk("R7 select above range", v, 0);
        rd_sel(16'hFFFF, v);
        chk("R7 select all-ones", v, 0);
        rd_sel(NI, v);
        chk("R7 select in range", v, 300 % (1 << CW));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule